// File: doc/BRIEF.md
# Half-Bridge Interlock and Dead-Time Controller

This block sits between a modulator and the gate drivers of one inverter leg. It receives a high-side command that is asserted high and a low-side command that is asserted low. From these it produces two registered gate enables. The block never lets both switches of the leg conduct together. A request that asks for both switches at once turns the leg off.

Each hand-over from one switch to the other passes through a programmable gap with both gates off. The gap is counted in clock cycles. The same gap is enforced after reset. Any request that arrives inside the gap is held off until the gap has elapsed. A request that is withdrawn before then produces no pulse at all.

Two inputs tri-state the leg whatever the commands are: an active-low stop input and an active-high fault-force input. A chip-level wrapper may instantiate three copies, one per phase.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: While `rst_n` is low, both `gate_hi` and `gate_lo` are 0.
- R2: With `stop_n`=1 and `fault_force`=0, the command pair `hi_cmd`=1, `lo_cmd_n`=1 requests the high switch and `hi_cmd`=0, `lo_cmd_n`=0 requests the low switch. Once the dead time is served, only the matching gate goes to 1.
- R3: If `stop_n` is 0 at a clock edge, both gates are 0 after that edge.
- R4: If `fault_force` is 1 at a clock edge, both gates are 0 after that edge.
- R5: If `hi_cmd`=1 and `lo_cmd_n`=0 at a clock edge (both switches requested), both gates are 0 after that edge.
- R6: If `hi_cmd`=0 and `lo_cmd_n`=1 at a clock edge (neither switch requested), both gates are 0 after that edge.
- R7: A gate rises only at an edge preceded by at least `DT_CYCLES` consecutive edges after which both gates were 0. Reset counts as the start of such a run with zero edges served. This also applies after an overlap, a stop or a fault.
- R8: A request held through the gap is granted without extra delay. If a gate falls at edge k, the other gate rises at edge k+`DT_CYCLES`.
- R9: A request withdrawn before its dead time has elapsed never produces a pulse on its gate.
- R10: A gate that is on stays on for as long as its request stays valid at each edge.
- R11: `gate_hi` and `gate_lo` are never 1 together, and a gate never rises at the edge where the other one falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the dead time is counted in its cycles |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd | input | 1 | High-switch command, asserted high |
| lo_cmd_n | input | 1 | Low-switch command, asserted low |
| stop_n | input | 1 | Leg stop, active low; tri-states the leg |
| fault_force | input | 1 | Fault force, active high; tri-states the leg |
| gate_hi | output | 1 | High-switch gate enable |
| gate_lo | output | 1 | Low-switch gate enable |

## Verification
The bench builds two copies that share one stimulus stream. One copy uses a six-cycle gap and the other a one-cycle gap. The six-cycle copy makes short random command pulses land inside the gap often, which exercises held-off and withdrawn requests and the exact grant edge. The one-cycle copy exercises the shortest legal gap, where a hand-over completes almost at once and the counter's saturation value equals its first count.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_HI  = 2'b01,
    LEG_LO  = 2'b10
  } leg_state_e;

  typedef struct packed {
    logic want_hi;
    logic want_lo;
  } leg_req_t;

endpackage

// File: rtl/hb_req_decode.sv
module hb_req_decode
  import hb_pkg::*;
(
  input  logic     hi_cmd,
  input  logic     lo_cmd_n,
  input  logic     stop_n,
  input  logic     fault_force,
  output leg_req_t req
);

  logic leg_allowed;
  logic hi_asked;
  logic lo_asked;

  // Normalise polarity: both asks are active high from here on.
  always_comb begin
    leg_allowed = stop_n & ~fault_force;
    hi_asked    = hi_cmd;
    lo_asked    = ~lo_cmd_n;
    // A simultaneous ask for both switches resolves to neither.
    req.want_hi = leg_allowed & hi_asked & ~lo_asked;
    req.want_lo = leg_allowed & lo_asked & ~hi_asked;
  end

endmodule

// File: rtl/hb_dt_timer.sv
module hb_dt_timer #(
  parameter int DT_CYCLES = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_nxt,
  output logic dt_done
);

  localparam int CW = (DT_CYCLES < 2) ? 1 : $clog2(DT_CYCLES + 1);
  localparam logic [CW-1:0] DT_MAX = CW'(DT_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Counts edges after which both gates are off; cleared while a gate is on.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!off_nxt) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q < DT_MAX) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign dt_done = (cnt_q == DT_MAX);

  // R7: the off-run counter saturates at the dead time and never passes it.
  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DT_MAX);

  // R7: a gate turning on clears the run, so it starts from zero.
  a_r7_cnt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !off_nxt |=> (cnt_q == '0));

endmodule

// File: rtl/hb_gate_fsm.sv
module hb_gate_fsm
  import hb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  leg_req_t req,
  input  logic     dt_done,
  output logic     gate_hi,
  output logic     gate_lo,
  output logic     off_nxt
);

  leg_state_e st_q;
  leg_state_e st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LEG_HI:  if (!req.want_hi) st_d = LEG_OFF;
      LEG_LO:  if (!req.want_lo) st_d = LEG_OFF;
      default: begin
        if (dt_done && req.want_hi)      st_d = LEG_HI;
        else if (dt_done && req.want_lo) st_d = LEG_LO;
        else                             st_d = LEG_OFF;
      end
    endcase
    off_nxt = (st_d == LEG_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LEG_OFF;
    end else begin
      st_q <= st_d;
    end
  end

  assign gate_hi = (st_q == LEG_HI);
  assign gate_lo = (st_q == LEG_LO);

  // R7: a rising gate needs the timer to have reported a full gap.
  a_r7_rise_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) || $rose(gate_lo)) |-> $past(dt_done));

  // R10: an active gate holds while its request stays valid.
  a_r10_hold_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi && req.want_hi) |=> gate_hi);
  a_r10_hold_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_lo && req.want_lo) |=> gate_lo);

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_pkg::*;
#(
  parameter int DT_CYCLES = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd,
  input  logic lo_cmd_n,
  input  logic stop_n,
  input  logic fault_force,
  output logic gate_hi,
  output logic gate_lo
);

  leg_req_t req;
  logic     dt_done;
  logic     off_nxt;

  hb_req_decode u_dec (
    .hi_cmd      (hi_cmd),
    .lo_cmd_n    (lo_cmd_n),
    .stop_n      (stop_n),
    .fault_force (fault_force),
    .req         (req)
  );

  hb_dt_timer #(.DT_CYCLES(DT_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .off_nxt (off_nxt),
    .dt_done (dt_done)
  );

  hb_gate_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .dt_done (dt_done),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo),
    .off_nxt (off_nxt)
  );

  // R3: stop pulls both gates off at the next edge.
  a_r3_stop_off: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |=> (!gate_hi && !gate_lo));

  // R4: fault force pulls both gates off at the next edge.
  a_r4_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_force |=> (!gate_hi && !gate_lo));

  // R5: a request for both switches resolves to both off.
  a_r5_overlap_off: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cmd && !lo_cmd_n) |=> (!gate_hi && !gate_lo));

  // R6: no request leaves both off.
  a_r6_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_cmd && lo_cmd_n) |=> (!gate_hi && !gate_lo));

  // R11: a gate rises only from a cycle where the other was already off.
  a_r11_no_swap_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> $past(!gate_lo));
  a_r11_no_swap_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> $past(!gate_hi));

endmodule

// File: tb/sim_hb_deadtime_ctrl.sv
module sim_hb_deadtime_ctrl;

  localparam int DT0 = 6;
  localparam int DT1 = 1;

  logic       clk;
  logic       rst_n;
  logic       hi_cmd;
  logic       lo_cmd_n;
  logic       stop_n;
  logic       fault_force;
  logic [1:0] g_hi;
  logic [1:0] g_lo;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit live   = 0;

  // Reference model state per instance.
  logic m_hi  [2];
  logic m_lo  [2];
  int   m_run [2];
  int   m_dt  [2];
  logic p_h, p_ln, p_s, p_f;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  hb_deadtime_ctrl #(.DT_CYCLES(DT0)) u0 (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd_n(lo_cmd_n),
    .stop_n(stop_n), .fault_force(fault_force),
    .gate_hi(g_hi[0]), .gate_lo(g_lo[0])
  );

  hb_deadtime_ctrl #(.DT_CYCLES(DT1)) u1 (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd_n(lo_cmd_n),
    .stop_n(stop_n), .fault_force(fault_force),
    .gate_hi(g_hi[1]), .gate_lo(g_lo[1])
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string tag, input logic gh, input logic gl,
                     input logic eh, input logic el);
    checks++;
    if (gh !== eh || gl !== el) begin
      errors++;
      $display("FAIL %s: got hi=%0b lo=%0b expected hi=%0b lo=%0b",
               tag, gh, gl, eh, el);
    end
  endtask

  // Requirement-level behaviour of one leg for one clock edge.
  task automatic model_step(input int k);
    logic wh, wl;
    wh = p_h && p_ln && p_s && !p_f;
    wl = !p_h && !p_ln && p_s && !p_f;
    if (m_hi[k]) begin
      if (!wh) begin m_hi[k] = 1'b0; m_run[k] = 1; end
    end else if (m_lo[k]) begin
      if (!wl) begin m_lo[k] = 1'b0; m_run[k] = 1; end
    end else if (m_run[k] >= m_dt[k] && wh) begin
      m_hi[k] = 1'b1; m_run[k] = 0;
    end else if (m_run[k] >= m_dt[k] && wl) begin
      m_lo[k] = 1'b1; m_run[k] = 0;
    end else if (m_run[k] < m_dt[k]) begin
      m_run[k]++;
    end
  endtask

  function automatic string tag_of(input logic eh, input logic el);
    if (!p_s)              return "R3";
    if (p_f)               return "R4";
    if (p_h && !p_ln)      return "R5";
    if (!p_h && p_ln)      return "R6";
    if (eh || el)          return "R2/R10";
    return "R7/R9";
  endfunction

  initial begin
    m_dt[0] = DT0;
    m_dt[1] = DT1;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_hi[k] = 1'b0; m_lo[k] = 1'b0; m_run[k] = 0;
      end
    end else begin
      p_h = hi_cmd; p_ln = lo_cmd_n; p_s = stop_n; p_f = fault_force;
      for (int k = 0; k < 2; k++) model_step(k);
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (live && rst_n) begin
      for (int k = 0; k < 2; k++) begin
        chk(tag_of(m_hi[k], m_lo[k]), g_hi[k], g_lo[k], m_hi[k], m_lo[k]);
        checks++;
        if (g_hi[k] && g_lo[k]) begin
          errors++;
          $display("FAIL R11: got hi=1 lo=1 expected not both");
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got cycle=%0d expected end before 150000", cyc);
      report();
      $finish;
    end
  end

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic h, input logic ln, input logic s, input logic f);
    hi_cmd = h; lo_cmd_n = ln; stop_n = s; fault_force = f;
  endtask

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 1'b0);   // high request already present
    negs(3);
    chk("R1", g_hi[0], g_lo[0], 1'b0, 1'b0);
    chk("R1", g_hi[1], g_lo[1], 1'b0, 1'b0);
    rst_n = 1'b1;
    live  = 1'b1;

    // R7 after reset: DT0 edges of off before the first rise; R8 exact edge.
    negs(DT0);
    chk("R7", g_hi[0], g_lo[0], 1'b0, 1'b0);
    negs(1);
    chk("R8", g_hi[0], g_lo[0], 1'b1, 1'b0);
    chk("R2", g_hi[1], g_lo[1], 1'b1, 1'b0);

    // Hand-over high -> low.
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    negs(1);
    chk("R11", g_hi[0], g_lo[0], 1'b0, 1'b0);
    negs(DT0 - 1);
    chk("R7", g_hi[0], g_lo[0], 1'b0, 1'b0);
    negs(1);
    chk("R8", g_hi[0], g_lo[0], 1'b0, 1'b1);

    // R9: high request withdrawn inside the gap never pulses.
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    negs(3);
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 12; i++) begin
        negs(1);
        seen = seen | g_hi[0];
      end
      chk("R9", seen, g_lo[0], 1'b0, 1'b0);
    end

    // R5 overlap, then gap again before re-grant (R7).
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    negs(2);
    chk("R2", g_hi[0], g_lo[0], 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    negs(1);
    chk("R5", g_hi[0], g_lo[0], 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    negs(DT0 - 1);
    chk("R7", g_hi[0], g_lo[0], 1'b0, 1'b0);
    negs(1);
    chk("R10", g_hi[0], g_lo[0], 1'b1, 1'b0);
    negs(5);
    chk("R10", g_hi[0], g_lo[0], 1'b1, 1'b0);

    // R3 stop.
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    negs(1);
    chk("R3", g_hi[0], g_lo[0], 1'b0, 1'b0);
    chk("R3", g_hi[1], g_lo[1], 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    negs(DT0 + 2);
    chk("R2", g_hi[0], g_lo[0], 1'b0, 1'b1);

    // R4 fault.
    drive(1'b0, 1'b0, 1'b1, 1'b1);
    negs(1);
    chk("R4", g_hi[0], g_lo[0], 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    negs(DT0 + 2);
    // R6 idle.
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    negs(1);
    chk("R6", g_hi[0], g_lo[0], 1'b0, 1'b0);

    // Constrained random segments.
    for (int seg = 0; seg < 600; seg++) begin
      int r, c, len;
      r   = int'($urandom % 16);
      c   = int'($urandom % 4);
      len = 1 + int'($urandom % 12);
      drive(c[0], c[1], (r != 0), (r == 1));
      negs(len);
    end

    report();
    $finish;
  end

endmodule